// File: doc/BRIEF.md
# In-Order Group Slotting Issue Stage

This stage sits between instruction decode and the execution units of an in-order superscalar pipeline. It accepts one aligned group of four decoded instructions at a time from the upstream slot stage, holds it, and each cycle hands out issue grants to as many of the held instructions as the execution units can take, always in program order. An instruction that finds no free unit of its class stops everything behind it in the same group for that cycle.

A group is never mixed with another. Leftovers of a partly issued group stay in place, and the next group is only taken once every valid instruction of the current one has issued. Execution resources that are free but unused in the meantime stay idle. Instructions that are issued in order may still complete out of order in multi-cycle units; that is outside this stage. A flush drops the held group in one cycle.

Each cycle the execution side reports, per unit class, how many units can start an operation. Grants consume those counts slot by slot, lowest slot first.

Top module: `group_issue_slot`

## Requirements
- R1: After reset no instruction is held, `issue_grant` is zero and `grp_ready` is high.
- R2: A group on the inputs is taken on a rising edge where `grp_valid` and `grp_ready` are both high; its slots with `grp_slot_vld` set become pending and may be granted from the next cycle on, with their class codes shown on `issue_cls`.
- R3: Grants form an in-order prefix: no slot is granted while a lower pending slot of the same group stays ungranted in that cycle.
- R4: Per class c, the number of slots granted in a cycle whose 2-bit code (bits [2i+1:2i] of the held classes for slot i) equals c never exceeds the free count of class c, read from bits [3c+2:3c] of `unit_free`.
- R5: The grant vector is the longest such prefix: a pending slot is granted whenever every lower pending slot is granted and a unit of its class remains after the lower grants of that class are counted.
- R6: Slots that are not valid are never granted and do not block higher slots.
- R7: While any pending slot would remain ungranted at the end of the cycle, `grp_ready` is low and no new group is taken, even when units are free.
- R8: `grp_ready` is high, with no flush, in the cycle the last pending slot is granted and in every cycle the stage holds nothing.
- R9: In a cycle with `flush` high no grant is given and `grp_ready` is low; from the next cycle the stage holds nothing.
- R10: Each slot of a taken group is granted at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the held group |
| grp_valid | input | 1 | Upstream offers a group |
| grp_slot_vld | input | 4 | Per-slot valid bits of the offered group, slot 0 oldest |
| grp_cls | input | 8 | Unit-class code per slot, 2 bits each |
| unit_free | input | 12 | Free unit count per class, 3 bits each, class 0 lowest |
| grp_ready | output | 1 | Stage takes the offered group at this edge |
| issue_grant | output | 4 | Per-slot issue grant this cycle |
| issue_cls | output | 8 | Class codes of the held group |

## Verification
The assertions take for granted only that the inputs carry known values once reset is released; every 2-bit class code names a real class, so no code can fall outside the free-count vector. Free counts are unconstrained, including zero for every class, so the bench drives them from a cycling pattern that includes starved cycles and, every fourth cycle, enough units for every slot so each group finishes. The offered group is held on the inputs until the stage takes it, with `grp_valid` dropped on some cycles and occasional flushes landing mid-group, and the sweep covers every slot-valid pattern against sixteen class mixes.

// File: rtl/group_issue_slot.sv
module group_issue_slot #(
  parameter int SLOTS = 4,
  parameter int CW    = 2,
  parameter int FW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  grp_valid,
  input  logic [SLOTS-1:0]      grp_slot_vld,
  input  logic [SLOTS*CW-1:0]   grp_cls,
  input  logic [(1<<CW)*FW-1:0] unit_free,
  output logic                  grp_ready,
  output logic [SLOTS-1:0]      issue_grant,
  output logic [SLOTS*CW-1:0]   issue_cls
);
  localparam int NCLS = 1 << CW;

  logic [SLOTS-1:0]    pend;
  logic [SLOTS*CW-1:0] cls_q;
  logic [FW-1:0]       left [NCLS];
  logic                stop;
  logic [SLOTS-1:0]    remain;

  always_comb begin
    for (int c = 0; c < NCLS; c++) left[c] = unit_free[c*FW +: FW];
    stop        = flush;
    issue_grant = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (pend[i] && !stop) begin
        if (left[cls_q[i*CW +: CW]] != '0) begin
          issue_grant[i]            = 1'b1;
          left[cls_q[i*CW +: CW]]   = left[cls_q[i*CW +: CW]] - 1'b1;
        end else begin
          stop = 1'b1;
        end
      end
    end
  end

  assign remain    = pend & ~issue_grant;
  assign grp_ready = !flush && (remain == '0);
  assign issue_cls = cls_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      cls_q <= '0;
    end else if (flush) begin
      pend  <= '0;
    end else if (grp_valid && grp_ready) begin
      pend  <= grp_slot_vld;
      cls_q <= grp_cls;
    end else begin
      pend  <= remain;
    end
  end
endmodule

// File: rtl/group_issue_slot_chk.sv
module group_issue_slot_chk #(
  parameter int SLOTS = 4,
  parameter int CW    = 2,
  parameter int FW    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  grp_valid,
  input logic [SLOTS-1:0]      grp_slot_vld,
  input logic [(1<<CW)*FW-1:0] unit_free,
  input logic                  grp_ready,
  input logic [SLOTS-1:0]      issue_grant,
  input logic [SLOTS*CW-1:0]   issue_cls,
  input logic [SLOTS-1:0]      pend
);
  localparam int NCLS = 1 << CW;
  localparam int UW   = $clog2(SLOTS + 1);

  logic [SLOTS-1:0] hole;
  always_comb begin
    hole = '0;
    for (int i = 0; i < SLOTS; i++)
      for (int j = i + 1; j < SLOTS; j++)
        if (pend[i] && !issue_grant[i] && issue_grant[j]) hole[i] = 1'b1;
  end

  p_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n) hole == '0);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [UW-1:0] used;
    always_comb begin
      used = '0;
      for (int i = 0; i < SLOTS; i++)
        if (issue_grant[i] && issue_cls[i*CW +: CW] == CW'(c)) used = used + 1'b1;
    end
    p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(used) <= 32'(unit_free[c*FW +: FW]));
  end

  p_only_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant & ~pend) == '0);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid && grp_ready |=> pend == $past(grp_slot_vld));
  p_nomerge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~issue_grant) != '0 |-> !grp_ready);
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && (pend & ~issue_grant) == '0 |-> grp_ready);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> issue_grant == '0 && !grp_ready);
  p_flush_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> pend == '0);
  p_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant != '0) && !grp_ready |=> (issue_grant & $past(issue_grant)) == '0);
endmodule

bind group_issue_slot group_issue_slot_chk #(.SLOTS(SLOTS), .CW(CW), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .grp_valid(grp_valid),
  .grp_slot_vld(grp_slot_vld), .unit_free(unit_free), .grp_ready(grp_ready),
  .issue_grant(issue_grant), .issue_cls(issue_cls), .pend(pend)
);

// File: tb/group_issue_slot_tb_top.sv
module group_issue_slot_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        grp_valid = 1'b0;
  logic [3:0]  grp_slot_vld = '0;
  logic [7:0]  grp_cls = '0;
  logic [11:0] unit_free = '0;
  logic        grp_ready;
  logic [3:0]  issue_grant;
  logic [7:0]  issue_cls;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  group_issue_slot dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .grp_valid(grp_valid),
    .grp_slot_vld(grp_slot_vld), .grp_cls(grp_cls), .unit_free(unit_free),
    .grp_ready(grp_ready), .issue_grant(issue_grant), .issue_cls(issue_cls)
  );

  logic [3:0] m_pend = '0;
  logic [7:0] m_cls  = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] grp_vld_of(int idx);
    return 4'(idx % 16);
  endfunction

  function automatic logic [7:0] grp_cls_of(int idx);
    return 8'(((idx / 16) * 29 + idx * 7) % 256);
  endfunction

  function automatic logic [11:0] free_of(int cyc);
    logic [11:0] f;
    for (int c = 0; c < 4; c++)
      f[c*3 +: 3] = (cyc % 4 == 0) ? 3'd4 : 3'((cyc * 5 + c * 3) % 4);
    return f;
  endfunction

  // Slot k is expected granted when it is pending and, for every pending slot j
  // up to k, the pending slots at or below j with j's class fit j's free count.
  function automatic logic [3:0] exp_grant(logic [3:0] pend, logic [7:0] cls,
                                           logic [11:0] free, bit fl);
    logic [3:0] g = '0;
    if (fl) return g;
    for (int k = 0; k < 4; k++) begin
      bit fits = pend[k];
      for (int j = 0; j <= k; j++) begin
        if (pend[j]) begin
          int n = 0;
          for (int i = 0; i <= j; i++)
            if (pend[i] && cls[i*2 +: 2] == cls[j*2 +: 2]) n++;
          if (n > int'(free[cls[j*2 +: 2]*3 +: 3])) fits = 0;
        end
      end
      g[k] = fits;
    end
    return g;
  endfunction

  initial begin
    int idx = 0;
    int cyc = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    unit_free = 12'hFFF;
    #1;
    check(issue_grant == 4'h0, "R1 grant", issue_grant, 0);
    check(grp_ready == 1'b1, "R1 ready", grp_ready, 1);

    while (idx < 256 && cyc < 20000) begin
      logic [3:0] eg;
      bit er;
      @(negedge clk);
      flush        = (cyc % 53 == 20);
      grp_valid    = (cyc % 7 != 3);
      grp_slot_vld = grp_vld_of(idx);
      grp_cls      = grp_cls_of(idx);
      unit_free    = free_of(cyc);
      #1;
      eg = exp_grant(m_pend, m_cls, unit_free, flush);
      er = !flush && ((m_pend & ~eg) == 4'h0);
      if (flush) begin
        check(issue_grant == eg, "R9 grant", issue_grant, eg);
        check(grp_ready == er, "R9 ready", grp_ready, er);
      end else begin
        check(issue_grant == eg, "R2 R3 R4 R5 R6 R10 grant", issue_grant, eg);
        check(grp_ready == er, (m_pend == 4'h0) ? "R8 ready" : "R7 R8 ready", grp_ready, er);
        if (m_pend != 4'h0)
          check(issue_cls == m_cls, "R2 class", issue_cls, m_cls);
      end
      @(posedge clk);
      if (flush) m_pend = 4'h0;
      else if (er && grp_valid) begin
        m_pend = grp_slot_vld;
        m_cls  = grp_cls;
        idx++;
      end else m_pend = m_pend & ~eg;
      cyc++;
    end
    if (cyc >= 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", idx, 256);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule